// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block watches a software heartbeat line and requests a system reset when the heartbeat stops. Any change of level on the line, either upward or downward, counts as a kick. The block counts in ticks of a slow time base supplied from outside. It does not count raw clock cycles.

Two windows are used. After every reset of any cause the block is in startup mode, which gives a long window so that a lengthy boot can finish. The first kick moves it to normal mode, which uses a short window. If a window runs out, the block raises a one-cycle expiry pulse for the reset sequencer and drops back to startup mode. While a reset is active the counter stays at zero. When an external detector reports the heartbeat line as unconnected, the watchdog is switched off.

Top module: `wdg_dual_window`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, `expire_pulse` is 0. The block leaves reset in startup mode with its counter at zero.
- R2: In startup mode with no kick, `expire_pulse` is 1 in the cycle after the `STARTUP_TICKS`-th tick since the counter was cleared, and 0 after every earlier tick.
- R3: `expire_pulse` lasts exactly one cycle. After an expiry in either mode, the block is in startup mode with a cleared counter.
- R4: A rising edge on `wdi` (a sample of 1 following a sample of 0) is a kick. A kick clears the counter and selects normal mode. A tick in the same cycle as a kick is not counted.
- R5: A falling edge on `wdi` (a sample of 0 following a sample of 1) is a kick with the same effect as a rising edge.
- R6: In normal mode, `expire_pulse` is 1 after the `NORMAL_TICKS`-th tick since the last kick. Kicks that come at least every `NORMAL_TICKS`-1 ticks prevent expiry indefinitely.
- R7: While `reset_active` is 1, the counter is held at zero, ticks are not counted, `wdi` edges are not kicks and `expire_pulse` stays 0. Counting resumes on the first tick after release.
- R8: A `reset_event` strobe returns the block to startup mode and clears the counter, whatever the current mode.
- R9: While `wdi_connected` is 0, the block never expires and ignores `wdi` edges and ticks.
- R10: When `wdi_connected` rises, the block restarts in startup mode with a cleared counter. A level change of `wdi` seen across the reconnection is not a kick.
- R11: Clock cycles without `tick` do not advance the window.
- R12: A `wdi` pulse that lasts a single clock sample produces kicks and moves the block to normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe from the slow time base |
| wdi | input | 1 | Synchronized heartbeat line |
| wdi_connected | input | 1 | 1 when the heartbeat line is driven, 0 when it is floating |
| reset_active | input | 1 | 1 while the system reset output is asserted |
| reset_event | input | 1 | One-cycle strobe marking a new reset of any cause |
| expire_pulse | output | 1 | One-cycle request for a reset, registered |

## Verification
The hardest case to reach is a mode change that the ports can only show through timing. Normal mode and startup mode have no output of their own, so the mode has to be inferred from the tick on which expiry finally arrives. Each scenario therefore ends by running ticks to the exact boundary of one window: one more or one fewer tick than expected shows up as a missing or early pulse. Reconnection, reset strobes and single-sample pulses are each followed by such a full window. A kick placed just short of the normal limit shows that both edge directions restart the count.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic {
    WM_STARTUP = 1'b0,
    WM_NORMAL  = 1'b1
  } wdg_mode_e;

  // Last counter value inside the window of the selected mode.
  function automatic int unsigned window_last(input wdg_mode_e mode,
                                              input int unsigned startup_ticks,
                                              input int unsigned normal_ticks);
    int unsigned len;
    len = (mode == WM_NORMAL) ? normal_ticks : startup_ticks;
    return len - 1;
  endfunction

  function automatic int unsigned larger(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdg_kick_detect.sv
module wdg_kick_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi,
  input  logic connected,
  output logic kick,
  output logic reconnect
);
  logic wdi_q;
  logic ref_valid_q;
  logic conn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdi_q       <= 1'b0;
      ref_valid_q <= 1'b0;
      conn_q      <= 1'b0;
    end else begin
      wdi_q       <= wdi;
      ref_valid_q <= connected;
      conn_q      <= connected;
    end
  end

  // An edge only counts when the previous sample was taken while connected.
  assign kick      = connected & ref_valid_q & (wdi ^ wdi_q);
  assign reconnect = connected & ~conn_q;

endmodule

// File: rtl/wdg_mode_ctrl.sv
module wdg_mode_ctrl
  import wdg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      to_startup,
  input  logic      to_normal,
  output wdg_mode_e mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode <= WM_STARTUP;
    else if (to_startup) mode <= WM_STARTUP;
    else if (to_normal)  mode <= WM_NORMAL;
  end
endmodule

// File: rtl/wdg_window_counter.sv
module wdg_window_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] last,
  output logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic             expire_q
);
  assign hit = tick & ~clear & (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= hit;
      if (clear || hit) cnt <= '0;
      else if (tick)    cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdg_dual_window.sv
module wdg_dual_window
  import wdg_pkg::*;
#(
  parameter int STARTUP_TICKS = 216,
  parameter int NORMAL_TICKS  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wdi,
  input  logic wdi_connected,
  input  logic reset_active,
  input  logic reset_event,
  output logic expire_pulse
);
  localparam int LIM_MAX = larger(STARTUP_TICKS, NORMAL_TICKS);
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  logic             raw_kick_w;
  logic             reconnect_w;
  logic             kick_w;
  logic             clear_w;
  logic             hit_w;
  logic             to_startup_w;
  wdg_mode_e        mode_w;
  logic [CNT_W-1:0] last_w;
  logic [CNT_W-1:0] cnt_w;

  wdg_kick_detect u_kick (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdi       (wdi),
    .connected (wdi_connected),
    .kick      (raw_kick_w),
    .reconnect (reconnect_w)
  );

  assign kick_w       = raw_kick_w & ~reset_active;
  assign clear_w      = reset_active | ~wdi_connected | kick_w | reconnect_w | reset_event;
  assign to_startup_w = reset_event | hit_w | reconnect_w;
  assign last_w       = CNT_W'(window_last(mode_w, STARTUP_TICKS, NORMAL_TICKS));

  wdg_mode_ctrl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .to_startup (to_startup_w),
    .to_normal  (kick_w),
    .mode       (mode_w)
  );

  wdg_window_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .clear    (clear_w),
    .last     (last_w),
    .cnt      (cnt_w),
    .hit      (hit_w),
    .expire_q (expire_pulse)
  );

endmodule

// File: rtl/wdg_dual_window_chk.sv
module wdg_dual_window_chk
  import wdg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wdi_connected,
  input logic             reset_active,
  input logic             reset_event,
  input logic             expire_pulse,
  input logic             kick_w,
  input wdg_mode_e        mode_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] last_w
);
  p_expire_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expire_pulse |-> $past(tick));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_pulse |=> !expire_pulse);

  p_expire_to_startup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_pulse |-> (mode_w == WM_STARTUP));

  p_kick_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kick_w |=> (cnt_w == '0));

  p_kick_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_w && !reset_event) |=> (mode_w == WM_NORMAL));

  p_count_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w <= last_w);

  p_held_in_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_active |=> ((cnt_w == '0) && !expire_pulse));

  p_event_startup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_event |=> (mode_w == WM_STARTUP));

  p_quiet_unplugged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wdi_connected |=> !expire_pulse);

endmodule

bind wdg_dual_window wdg_dual_window_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick          (tick),
  .wdi_connected (wdi_connected),
  .reset_active  (reset_active),
  .reset_event   (reset_event),
  .expire_pulse  (expire_pulse),
  .kick_w        (kick_w),
  .mode_w        (mode_w),
  .cnt_w         (cnt_w),
  .last_w        (last_w)
);

// File: tb/wdg_dual_window_bench.sv
module wdg_dual_window_bench;
  localparam int S = 216;
  localparam int N = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wdi = 1'b0;
  logic wdi_connected = 1'b1;
  logic reset_active = 1'b0;
  logic reset_event = 1'b0;
  logic expire_pulse;

  always #10 clk = ~clk;

  wdg_dual_window #(.STARTUP_TICKS(S), .NORMAL_TICKS(N)) u_wdg_dual_window (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .wdi           (wdi),
    .wdi_connected (wdi_connected),
    .reset_active  (reset_active),
    .reset_event   (reset_event),
    .expire_pulse  (expire_pulse)
  );

  typedef struct {
    int    due;
    bit    exp;
    string tag;
  } item_t;

  item_t exp_q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Monitor: compare each expected item in the cycle it falls due.
  always @(posedge clk) begin
    cyc = cyc + 1;
    #5;
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      item_t it;
      it = exp_q.pop_front();
      checks = checks + 1;
      if (expire_pulse !== it.exp) begin
        errors = errors + 1;
        $display("FAIL %s: expire_pulse=%0b expected %0b (cycle %0d)",
                 it.tag, expire_pulse, it.exp, cyc);
      end
    end
  end

  // Driver: apply one cycle of stimulus and queue the expected output.
  task automatic step(input bit t, input bit ra, input bit re, input bit e, input string tag);
    @(negedge clk);
    tick = t;
    reset_active = ra;
    reset_event = re;
    exp_q.push_back('{due: cyc + 1, exp: e, tag: tag});
  endtask

  task automatic run_ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic expire_tick(input string tag);
    step(1'b1, 1'b0, 1'b0, 1'b1, tag);
  endtask

  task automatic kick(input string tag);
    @(negedge clk);
    wdi = ~wdi;
    tick = 1'b1;   // a tick in the kick cycle must not be counted (R4)
    reset_active = 1'b0;
    reset_event = 1'b0;
    exp_q.push_back('{due: cyc + 1, exp: 1'b0, tag: tag});
  endtask

  task automatic full_startup(input string tag);
    run_ticks(S - 1, tag);
    expire_tick(tag);
  endtask

  task automatic full_normal(input string tag);
    run_ticks(N - 1, tag);
    expire_tick(tag);
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // R2: startup window, exact boundary
    full_startup("R2");
    // R3: single-cycle pulse, R11: idle cycles do not count
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R3_R11");
    full_startup("R11");
    // R4: rising edge enters normal mode
    kick("R4");
    full_normal("R4_R6");
    // R3: back in startup after a normal expiry
    full_startup("R3");
    // R5: falling edge restarts the normal window
    kick("R5");
    run_ticks(N - 3, "R5");
    kick("R5");
    full_normal("R5");
    // R6: steady kicks keep the block alive
    kick("R6");
    for (int r = 0; r < 5; r++) begin
      run_ticks(N - 1, "R6");
      kick("R6");
    end
    full_normal("R6");
    // R7: reset holds the counter and ignores kicks
    kick("R7");
    run_ticks(N - 2, "R7");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 2 * S; i++) begin
      if (i % 5 == 0) wdi = ~wdi;
      step(1'b1, 1'b1, 1'b0, 1'b0, "R7");
    end
    full_startup("R7");
    // R8: reset strobe alone forces startup
    kick("R8");
    run_ticks(N - 2, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R8");
    full_startup("R8");
    // R9: unconnected line disables the watchdog
    @(negedge clk);
    wdi_connected = 1'b0;
    for (int i = 0; i < 3 * S; i++) begin
      if (i % 3 == 0) wdi = ~wdi;
      step(1'b1, 1'b0, 1'b0, 1'b0, "R9");
    end
    // R10: reconnection restarts in startup with a level change across it
    wdi = ~wdi;
    @(negedge clk);
    wdi_connected = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, "R10");
    full_startup("R10");
    kick("R10");
    run_ticks(N - 2, "R10");
    @(negedge clk);
    wdi_connected = 1'b0;
    step(1'b0, 1'b0, 1'b0, 1'b0, "R10");
    @(negedge clk);
    wdi_connected = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, "R10");
    full_startup("R10");
    // R12: single-sample pulse
    run_ticks(S - 5, "R12");
    kick("R12");
    kick("R12");
    full_normal("R12");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R3");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int waited;
    waited = 0;
    while (!done && waited < 100000) begin
      @(posedge clk);
      waited = waited + 1;
    end
    if (!done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, expected completion within %0d cycles", waited);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule